// File: doc/BRIEF.md
# Integer Add/Subtract Execution Unit

This block is the add/subtract datapath of a 64-bit integer pipeline. It is purely combinational. Decode supplies two register operands, a 16-bit signed immediate, the address of the next instruction, a flag that marks the first register field as zero, the current carry and overflow bits, and an operation code. In the same cycle the block returns the 64-bit result, the new carry and overflow bits, and a one-hot sign/zero condition field.

Every operation goes through one adder. The adder's first input is either an operand or its bitwise complement. Its second input is the second register, an extended immediate, all ones or zero. Its carry-in is 0, 1, the carry bit or the overflow bit. Subtraction is therefore done as the complement of the first operand plus the second operand plus a carry-in. Two control bits from the instruction set the update policy. One allows the overflow bit to change. The other allows the condition field to be produced.

Top module: `fxu_addsub`

## Requirements
- R1: Immediate add (code 1) gives `A + sext(imm)`. When `ra_zero_i` is 1 it gives `sext(imm)` alone, whatever `opa_i` holds.
- R2: Shifted-immediate add (code 2) uses the immediate placed in bits 31:16, with zeros in bits 15:0, sign-extended from bit 31. The zero-base rule of R1 applies to it as well.
- R3: PC-relative shifted add (code 3) gives `nia_i + sext(imm << 16)`. It ignores `opa_i` and `ra_zero_i`.
- R4: Subtract-from forms give `~A + B + 1`, which equals `B - A`: code 4 (no carry update), code 6 (carrying) and code 8 (carrying, with `B` replaced by `sext(imm)`). Code 5 is a carrying add `A + B`. Code 7 is a carrying immediate add `A + sext(imm)`.
- R5: Extended forms use the incoming carry as carry-in. Code 9 gives `A + B + CA` and code 10 gives `~A + B + CA`.
- R6: Code 11 gives `A + all-ones + CA` and code 12 gives `~A + all-ones + CA`. Code 13 gives `A + CA` and code 14 gives `~A + CA`. Code 15 (negate) gives `~A + 1`.
- R7: Code 16 gives `A + B + OV`. Its adder carry-out drives `ov_o`, and `ca_o` equals `ca_i`.
- R8: `ca_o` is the carry out of bit 63 for codes 5 to 14. For codes 0 to 4, 15 and the unused codes, `ca_o` equals `ca_i`.
- R9: With `oe_i` = 1, `ov_o` is the signed overflow of the 64-bit add, except for code 16. With `oe_i` = 0, `ov_o` equals `ov_i`, except for code 16.
- R10: With `rc_i` = 1, `cr_o` is one-hot from the result: bit 2 is negative, bit 1 is positive, bit 0 is zero. With `rc_i` = 0, `cr_o` is 000.
- R11: Code 0 is a plain add `A + B` with no carry update. Codes 17 to 31 give a zero result and pass `ca_i` and `ov_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (see R1 to R11) |
| opa_i | input | 64 | First register operand A |
| opb_i | input | 64 | Second register operand B |
| imm_i | input | 16 | Signed immediate |
| nia_i | input | 64 | Next-instruction address |
| ra_zero_i | input | 1 | First register field is zero |
| ca_i | input | 1 | Incoming carry bit |
| ov_i | input | 1 | Incoming overflow bit |
| oe_i | input | 1 | Allow overflow update |
| rc_i | input | 1 | Produce condition field |
| sum_o | output | 64 | Result |
| ca_o | output | 1 | New carry bit |
| ov_o | output | 1 | New overflow bit |
| cr_o | output | 3 | Condition field {neg,pos,zero} |

## Verification
Three cases are hard to reach from the ports. The first is negating the most negative value, which has to overflow. The second is an extended subtract that borrows exactly at the boundary `A == B` with the carry set and with it clear. The third is the alternate-carry add, whose carry-out goes to `ov_o` while `ca_i` must pass through untouched. The directed tasks build each of these from chosen operand pairs. They drive opposite values on `ca_i` and `ov_i`, so that routing the wrong bit shows up at the outputs.

// File: rtl/fxu_addsub.sv
module fxu_addsub #(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [XLEN-1:0] nia_i,
  input  logic            ra_zero_i,
  input  logic            ca_i,
  input  logic            ov_i,
  input  logic            oe_i,
  input  logic            rc_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ca_o,
  output logic            ov_o,
  output logic [2:0]      cr_o
);
  localparam int SHW = 2 * IMMW;

  logic [XLEN-1:0] imm_s, imm_sh, base_a, x, y, res;
  logic            cin, cout, wr_ca, alt, valid, ovf;
  logic            neg, zero;

  assign imm_s  = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};
  assign imm_sh = {{(XLEN-SHW){imm_i[IMMW-1]}}, imm_i, {IMMW{1'b0}}};
  assign base_a = ra_zero_i ? '0 : opa_i;

  always_comb begin
    x     = opa_i;
    y     = opb_i;
    cin   = 1'b0;
    wr_ca = 1'b0;
    alt   = 1'b0;
    valid = 1'b1;
    case (op_i)
      5'd0:  ;
      5'd1:  begin x = base_a; y = imm_s; end
      5'd2:  begin x = base_a; y = imm_sh; end
      5'd3:  begin x = nia_i;  y = imm_sh; end
      5'd4:  begin x = ~opa_i; cin = 1'b1; end
      5'd5:  wr_ca = 1'b1;
      5'd6:  begin x = ~opa_i; cin = 1'b1; wr_ca = 1'b1; end
      5'd7:  begin y = imm_s; wr_ca = 1'b1; end
      5'd8:  begin x = ~opa_i; y = imm_s; cin = 1'b1; wr_ca = 1'b1; end
      5'd9:  begin cin = ca_i; wr_ca = 1'b1; end
      5'd10: begin x = ~opa_i; cin = ca_i; wr_ca = 1'b1; end
      5'd11: begin y = '1; cin = ca_i; wr_ca = 1'b1; end
      5'd12: begin x = ~opa_i; y = '1; cin = ca_i; wr_ca = 1'b1; end
      5'd13: begin y = '0; cin = ca_i; wr_ca = 1'b1; end
      5'd14: begin x = ~opa_i; y = '0; cin = ca_i; wr_ca = 1'b1; end
      5'd15: begin x = ~opa_i; y = '0; cin = 1'b1; end
      5'd16: begin cin = ov_i; alt = 1'b1; end
      default: begin x = '0; y = '0; valid = 1'b0; end
    endcase
  end

  assign {cout, res} = {1'b0, x} + {1'b0, y} + (XLEN+1)'(cin);
  assign ovf = (x[XLEN-1] == y[XLEN-1]) && (res[XLEN-1] != x[XLEN-1]);

  assign sum_o = valid ? res : '0;
  assign ca_o  = wr_ca ? cout : ca_i;
  assign ov_o  = alt ? cout : ((oe_i && valid) ? ovf : ov_i);

  assign neg  = sum_o[XLEN-1];
  assign zero = (sum_o == '0);
  assign cr_o = rc_i ? {neg, ~neg & ~zero, zero} : 3'b000;
endmodule

module fxu_addsub_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [IMMW-1:0] imm_i,
  input logic [XLEN-1:0] nia_i,
  input logic            ra_zero_i,
  input logic            ca_i,
  input logic            ov_i,
  input logic            oe_i,
  input logic            rc_i,
  input logic [XLEN-1:0] sum_o,
  input logic            ca_o,
  input logic            ov_o,
  input logic [2:0]      cr_o
);
  logic known;
  assign known = !$isunknown({op_i, opa_i, opb_i, imm_i, nia_i, ra_zero_i,
                              ca_i, ov_i, oe_i, rc_i});

  always_comb begin
    if (known) begin
      if (op_i == 5'd1 && ra_zero_i)
        a_r1_zero_base: assert (sum_o == {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i});
      if (op_i == 5'd4)
        a_r4_subf_diff: assert (sum_o == opb_i - opa_i);
      if (op_i == 5'd15)
        a_r6_neg_sum_zero: assert (sum_o + opa_i == '0);
      if (op_i == 5'd16)
        a_r7_alt_keeps_ca: assert (ca_o == ca_i);
      if (op_i <= 5'd4 || op_i == 5'd15 || op_i > 5'd16)
        a_r8_ca_pass: assert (ca_o == ca_i);
      if (!oe_i && op_i != 5'd16)
        a_r9_ov_hold: assert (ov_o == ov_i);
      if (rc_i)
        a_r10_cr_onehot: assert ($onehot(cr_o));
      else
        a_r10_cr_quiet: assert (cr_o == 3'b000);
      if (op_i > 5'd16)
        a_r11_unused_zero: assert (sum_o == '0);
    end
  end
endmodule

bind fxu_addsub fxu_addsub_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .nia_i(nia_i),
  .ra_zero_i(ra_zero_i), .ca_i(ca_i), .ov_i(ov_i), .oe_i(oe_i), .rc_i(rc_i),
  .sum_o(sum_o), .ca_o(ca_o), .ov_o(ov_o), .cr_o(cr_o)
);

// File: tb/tb_fxu_addsub.sv
module tb_fxu_addsub;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  op;
  logic [63:0] a, b, nia, sum;
  logic [15:0] imm;
  logic        rz, ca, ov, oe, rc, ca_q, ov_q;
  logic [2:0]  cr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  fxu_addsub dut (
    .op_i(op), .opa_i(a), .opb_i(b), .imm_i(imm), .nia_i(nia),
    .ra_zero_i(rz), .ca_i(ca), .ov_i(ov), .oe_i(oe), .rc_i(rc),
    .sum_o(sum), .ca_o(ca_q), .ov_o(ov_q), .cr_o(cr)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  function automatic logic [63:0] sx(logic [15:0] v);
    return {{48{v[15]}}, v};
  endfunction

  function automatic logic [63:0] sxh(logic [15:0] v);
    return {{32{v[15]}}, v, 16'h0};
  endfunction

  function automatic logic [64:0] add65(logic [63:0] p, logic [63:0] q, logic c);
    return {1'b0, p} + {1'b0, q} + {64'd0, c};
  endfunction

  function automatic logic sovf(logic [63:0] p, logic [63:0] q, logic c);
    logic signed [65:0] t;
    t = $signed({{2{p[63]}}, p}) + $signed({{2{q[63]}}, q}) + $signed({65'd0, c});
    return (t > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (t < -66'sh0_8000_0000_0000_0000);
  endfunction

  task automatic t_reset_state();
    op = 0; a = 0; b = 0; imm = 0; nia = 0; rz = 0; ca = 0; ov = 0; oe = 0; rc = 1;
    settle();
    chk("R11 idle sum", sum, 0);
    chk("R10 idle cr zero", {61'd0, cr}, 3'b001);
    chk("R8 idle ca", {63'd0, ca_q}, 0);
    chk("R9 idle ov", {63'd0, ov_q}, 0);
  endtask

  task automatic t_imm();
    op = 1; a = 64'h1234; imm = 16'hFFF0; rz = 0; rc = 0;
    settle(); chk("R1 addi", sum, 64'h1224);
    rz = 1; settle(); chk("R1 addi zero base", sum, 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R10 rc off", {61'd0, cr}, 0);
    op = 2; imm = 16'h8001; rz = 0; a = 64'h10;
    settle(); chk("R2 addis", sum, 64'hFFFF_FFFF_8001_0010);
    rz = 1; settle(); chk("R2 addis zero base", sum, 64'hFFFF_FFFF_8001_0000);
    op = 3; nia = 64'h0000_0001_0000_0004; imm = 16'h0002; a = 64'hDEAD;
    settle(); chk("R3 pc rel", sum, 64'h0000_0001_0002_0004);
    rz = 0; imm = 16'hFFFF; settle(); chk("R3 pc rel neg", sum, 64'h0000_0000_FFFF_0004);
    rz = 0;
  endtask

  task automatic t_subf();
    logic [64:0] e;
    op = 4; a = 64'd100; b = 64'd30; ca = 1; oe = 0;
    settle(); chk("R4 subf", sum, 64'd30 - 64'd100);
    chk("R8 subf keeps ca", {63'd0, ca_q}, 1);
    op = 6; ca = 0;
    e = add65(~a, b, 1'b1);
    settle(); chk("R4 subfc", sum, e[63:0]); chk("R4 subfc borrow ca", {63'd0, ca_q}, 0);
    a = 64'd30; b = 64'd30; settle(); chk("R4 subfc equal ca", {63'd0, ca_q}, 1);
    op = 8; a = 64'd5; imm = 16'hFFFE;
    e = add65(~a, sx(imm), 1'b1);
    settle(); chk("R4 subfic", sum, 64'hFFFF_FFFF_FFFF_FFF9);
    chk("R4 subfic ca", {63'd0, ca_q}, {63'd0, e[64]});
    op = 5; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'd2; ca = 0;
    settle(); chk("R4 addc", sum, 64'd1); chk("R4 addc ca", {63'd0, ca_q}, 1);
    op = 7; a = 64'd3; imm = 16'hFFFF;
    settle(); chk("R4 addic", sum, 64'd2); chk("R4 addic ca", {63'd0, ca_q}, 1);
  endtask

  task automatic t_ext();
    op = 9; a = 64'd7; b = 64'd8; ca = 1;
    settle(); chk("R5 adde", sum, 64'd16); chk("R5 adde ca", {63'd0, ca_q}, 0);
    op = 10; a = 64'd9; b = 64'd9; ca = 0;
    settle(); chk("R5 subfe equal ca0", sum, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5 subfe ca0 out", {63'd0, ca_q}, 0);
    ca = 1; settle(); chk("R5 subfe equal ca1", sum, 0);
    chk("R5 subfe ca1 out", {63'd0, ca_q}, 1);
  endtask

  task automatic t_me_ze_neg();
    op = 11; a = 64'd10; ca = 0;
    settle(); chk("R6 addme", sum, 64'd9); chk("R6 addme ca", {63'd0, ca_q}, 1);
    op = 12; ca = 1; settle(); chk("R6 subfme", sum, ~64'd10);
    op = 13; ca = 1; a = 64'hFFFF_FFFF_FFFF_FFFF;
    settle(); chk("R6 addze", sum, 0); chk("R6 addze ca", {63'd0, ca_q}, 1);
    op = 14; a = 64'd4; ca = 1; settle(); chk("R6 subfze", sum, 64'hFFFF_FFFF_FFFF_FFFC);
    op = 15; a = 64'd6; ca = 0; oe = 1; ov = 0;
    settle(); chk("R6 neg", sum, -64'd6); chk("R8 neg keeps ca", {63'd0, ca_q}, 0);
    a = 64'h8000_0000_0000_0000;
    settle(); chk("R6 neg min", sum, 64'h8000_0000_0000_0000);
    chk("R9 neg min ov", {63'd0, ov_q}, 1);
    oe = 0;
  endtask

  task automatic t_alt();
    op = 16; a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'd0; ov = 1; ca = 0; oe = 1;
    settle(); chk("R7 alt sum", sum, 0); chk("R7 alt ov carry", {63'd0, ov_q}, 1);
    chk("R7 alt ca pass", {63'd0, ca_q}, 0);
    a = 64'd1; b = 64'd2; ov = 0; ca = 1;
    settle(); chk("R7 alt no carry", sum, 64'd3); chk("R7 alt ov 0", {63'd0, ov_q}, 0);
    chk("R7 alt ca 1", {63'd0, ca_q}, 1);
    oe = 0;
  endtask

  task automatic t_ovf();
    op = 0; a = 64'h7FFF_FFFF_FFFF_FFFF; b = 64'd1; ov = 0; oe = 1; ca = 1;
    settle(); chk("R9 add ovf", {63'd0, ov_q}, {63'd0, sovf(a, b, 1'b0)});
    chk("R11 add no ca update", {63'd0, ca_q}, 1);
    oe = 0; settle(); chk("R9 oe off hold 0", {63'd0, ov_q}, 0);
    ov = 1; a = 1; settle(); chk("R9 oe off hold 1", {63'd0, ov_q}, 1);
    oe = 1; settle(); chk("R9 no ovf clears", {63'd0, ov_q}, 0);
    op = 4; a = 64'd1; b = 64'h8000_0000_0000_0000;
    settle(); chk("R9 subf ovf", {63'd0, ov_q}, {63'd0, sovf(~a, b, 1'b1)});
    oe = 0; ov = 0;
  endtask

  task automatic t_cr();
    rc = 1; op = 0; a = 64'd5; b = 64'd3;
    settle(); chk("R10 positive", {61'd0, cr}, 3'b010);
    b = -64'd9; settle(); chk("R10 negative", {61'd0, cr}, 3'b100);
    b = -64'd5; settle(); chk("R10 zero", {61'd0, cr}, 3'b001);
    rc = 0; settle(); chk("R10 rc clear", {61'd0, cr}, 0);
  endtask

  task automatic t_unused();
    op = 5'd23; a = 64'd77; b = 64'd88; ca = 1; ov = 1; oe = 1; rc = 1;
    settle(); chk("R11 unused sum", sum, 0);
    chk("R11 unused ca", {63'd0, ca_q}, 1); chk("R11 unused ov", {63'd0, ov_q}, 1);
    chk("R11 unused cr", {61'd0, cr}, 3'b001);
    op = 5'd31; ca = 0; ov = 0; settle();
    chk("R11 top code ca", {63'd0, ca_q}, 0); chk("R11 top code ov", {63'd0, ov_q}, 0);
  endtask

  initial begin
    t_reset_state();
    t_imm();
    t_subf();
    t_ext();
    t_me_ze_neg();
    t_alt();
    t_ovf();
    t_cr();
    t_unused();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule